// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block places a two-way set-associative cache between a processor request port and a main-memory port. Each set holds two lines. Every line has a valid bit, a tag, one 32-bit data word, a use bit and a dirty bit. On each processor request the block compares the tag against both ways of the indexed set. A hit completes at once. A miss runs a memory sequence: an optional write-back of the victim, then a line fill, then completion of the original access.

The replacement policy keeps one use bit per line. Referencing a line sets its own use bit and clears the use bit of its partner in the set. An invalid line is always filled before either valid line is displaced. The static parameter `WRITE_BACK` selects the write policy. In write-back mode, writes stay in the cache and mark the line dirty, and a dirty victim is written to memory before it is replaced. In write-through mode, every write is also sent to memory and lines never become dirty. Writes allocate on a miss in both modes.

The processor holds `cpuValid` and its request fields steady until `cpuReady` is high at a clock edge. The memory side works the same way: `memReq` and its fields stay steady until `memAck`, and fill data is taken from `memRdata` in the acknowledge cycle. The default build has 64 sets. The full-size configuration sets `SET_BITS` to 13, which gives 8K sets and a 9-bit tag in a 22-bit block number.

Top module: `twoway_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any block is a miss. `cpuReady` and `memReq` are low while no request is pending.
- R2: A read hit raises `cpuReady` in the cycle the request is presented and returns the stored word. `cpuReady` is never high without `cpuValid`.
- R3: Byte address bits [1:0] are ignored. Bits [SET_BITS+1:2] select the set, and the bits above them form the tag. The memory block address is byte address bits [23:2].
- R4: On a miss, way 0 is filled if it is invalid. Otherwise way 1 is filled if it is invalid. The use bits play no part while an invalid way exists.
- R5: A reference sets the use bit of the referenced line and clears the other line's use bit. When both lines are valid, the line whose use bit is 0 is replaced.
- R6: In write-back mode, a write hit completes in the cycle it is presented, updates only the cached word, marks the line dirty and makes no memory request.
- R7: In write-back mode, a dirty victim is written to memory at its own block address, with its data, before the fill. A clean victim is overwritten with no memory write.
- R8: A miss runs the write-back (if any), then the fill, then completion. `cpuReady` stays low until the access completes, and the processor request is assumed to be held steady.
- R9: In write-through mode, a write hit updates the cache and issues a memory write carrying the processor's block address and data. It completes on the memory acknowledge. No victim is ever written back.
- R10: A write miss fills the line from memory and then performs the write as a hit under the active policy.
- R11: A memory request keeps `memReq`, `memWrite`, `memAddr` and `memWdata` unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuValid | input | 1 | Processor request pending |
| cpuWrite | input | 1 | 1 for a write, 0 for a read |
| cpuAddr | input | BLOCK_BITS+2 (24) | Processor byte address |
| cpuWdata | input | DATA_W (32) | Processor write word |
| cpuReady | output | 1 | Access completes at this edge |
| cpuRdata | output | DATA_W (32) | Read word, valid with cpuReady on a read |
| memReq | output | 1 | Memory request pending |
| memWrite | output | 1 | 1 for a memory write, 0 for a fill |
| memAddr | output | BLOCK_BITS (22) | Memory block address |
| memWdata | output | DATA_W (32) | Word written to memory |
| memAck | input | 1 | Memory completes the request at this edge |
| memRdata | input | DATA_W (32) | Fill word, valid with memAck |

## Verification
The assertions assume that the processor holds its request fields steady from the cycle `cpuValid` rises until `cpuReady` is seen. They also assume that memory acknowledges only while `memReq` is high. Without the first assumption, the victim chosen at the miss and the later fill would refer to different sets. The bench drives each request one time unit after a rising edge and holds it unchanged until the completing edge. Its memory model raises `memAck` for exactly one cycle, one cycle after each new request, so both assumptions hold throughout the run.

// File: rtl/twoway_cache_pkg.sv
package twoway_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WTMEM
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic touch;        // update use bits of the hit way
    logic wrData;       // write cpu word into the hit way
    logic fill;         // install memory word into latched victim way
    logic latchVictim;  // capture victim way at the miss
    logic selVictim;    // steer victim line onto the memory port
  } ctlStrobe_t;

endpackage

// File: rtl/twoway_cache_dp.sv
module twoway_cache_dp
  import twoway_cache_pkg::*;
#(
  parameter int SET_BITS   = 6,
  parameter int BLOCK_BITS = 22,
  parameter int DATA_W     = 32,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctlStrobe_t            strobe,
  input  logic [BLOCK_BITS-1:0] cpuBlock,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [DATA_W-1:0]     memRdata,
  output logic                  hit,
  output logic                  evictNeeded,
  output logic [DATA_W-1:0]     cpuRdata,
  output logic [BLOCK_BITS-1:0] memAddr,
  output logic [DATA_W-1:0]     memWdata
);

  localparam int SETS     = 1 << SET_BITS;
  localparam int WAYS     = 2;
  localparam int TAG_BITS = BLOCK_BITS - SET_BITS;

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_BITS-1:0] reqTag;

  assign setIdx = cpuBlock[SET_BITS-1:0];
  assign reqTag = cpuBlock[BLOCK_BITS-1:SET_BITS];

  logic [TAG_BITS-1:0] tagMem  [SETS][WAYS];
  logic [DATA_W-1:0]   dataMem [SETS][WAYS];
  logic [WAYS-1:0]     validBits [SETS];
  logic [WAYS-1:0]     dirtyBits [SETS];
  logic [WAYS-1:0]     useBits   [SETS];

  logic [WAYS-1:0] wayHit;
  logic            hitWay;
  logic            victimWayC;
  logic            victimWayQ;

  // Tag compare per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validBits[setIdx][w] && (tagMem[setIdx][w] == reqTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  // Invalid way first, then the way whose use bit is clear
  always_comb begin
    if (!validBits[setIdx][0]) begin
      victimWayC = 1'b0;
    end else if (!validBits[setIdx][1]) begin
      victimWayC = 1'b1;
    end else begin
      victimWayC = useBits[setIdx][0];
    end
  end

  assign evictNeeded = validBits[setIdx][victimWayC] && dirtyBits[setIdx][victimWayC];

  // Line state bits
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validBits[s] <= '0;
        dirtyBits[s] <= '0;
        useBits[s]   <= '0;
      end
      victimWayQ <= 1'b0;
    end else begin
      if (strobe.latchVictim) begin
        victimWayQ <= victimWayC;
      end
      if (strobe.touch) begin
        useBits[setIdx][hitWay]  <= 1'b1;
        useBits[setIdx][!hitWay] <= 1'b0;
      end
      if (strobe.wrData && WRITE_BACK) begin
        dirtyBits[setIdx][hitWay] <= 1'b1;
      end
      if (strobe.fill) begin
        validBits[setIdx][victimWayQ] <= 1'b1;
        dirtyBits[setIdx][victimWayQ] <= 1'b0;
      end
    end
  end

  // Tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagMem[setIdx][victimWayQ]  <= reqTag;
      dataMem[setIdx][victimWayQ] <= memRdata;
    end else if (strobe.wrData) begin
      dataMem[setIdx][hitWay] <= cpuWdata;
    end
  end

  assign cpuRdata = dataMem[setIdx][hitWay];
  assign memAddr  = strobe.selVictim ? {tagMem[setIdx][victimWayQ], setIdx} : cpuBlock;
  assign memWdata = strobe.selVictim ? dataMem[setIdx][victimWayQ] : cpuWdata;

endmodule

// File: rtl/twoway_cache_ctrl.sv
module twoway_cache_ctrl
  import twoway_cache_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       hit,
  input  logic       evictNeeded,
  input  logic       memAck,
  output ctlStrobe_t strobe,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWrite
);

  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuValid) begin
          if (hit) begin
            if (cpuWrite && !WRITE_BACK) begin
              nextState = ST_WTMEM;
            end else begin
              cpuReady      = 1'b1;
              strobe.touch  = 1'b1;
              strobe.wrData = cpuWrite;
            end
          end else begin
            strobe.latchVictim = 1'b1;
            nextState = (WRITE_BACK && evictNeeded) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        memReq           = 1'b1;
        memWrite         = 1'b1;
        strobe.selVictim = 1'b1;
        if (memAck) begin
          nextState = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fill = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      ST_WTMEM: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) begin
          cpuReady      = 1'b1;
          strobe.touch  = 1'b1;
          strobe.wrData = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/twoway_cache.sv
module twoway_cache
  import twoway_cache_pkg::*;
#(
  parameter int SET_BITS   = 6,
  parameter int BLOCK_BITS = 22,
  parameter int DATA_W     = 32,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpuValid,
  input  logic                    cpuWrite,
  input  logic [BLOCK_BITS+1:0]   cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  output logic                    cpuReady,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    memReq,
  output logic                    memWrite,
  output logic [BLOCK_BITS-1:0]   memAddr,
  output logic [DATA_W-1:0]       memWdata,
  input  logic                    memAck,
  input  logic [DATA_W-1:0]       memRdata
);

  localparam int ADDR_W = BLOCK_BITS + 2;

  ctlStrobe_t            strobe;
  logic                  hit;
  logic                  evictNeeded;
  logic [BLOCK_BITS-1:0] cpuBlock;

  assign cpuBlock = cpuAddr[ADDR_W-1:2];

  twoway_cache_ctrl #(
    .WRITE_BACK(WRITE_BACK)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .cpuValid   (cpuValid),
    .cpuWrite   (cpuWrite),
    .hit        (hit),
    .evictNeeded(evictNeeded),
    .memAck     (memAck),
    .strobe     (strobe),
    .cpuReady   (cpuReady),
    .memReq     (memReq),
    .memWrite   (memWrite)
  );

  twoway_cache_dp #(
    .SET_BITS  (SET_BITS),
    .BLOCK_BITS(BLOCK_BITS),
    .DATA_W    (DATA_W),
    .WRITE_BACK(WRITE_BACK)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cpuBlock   (cpuBlock),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .hit        (hit),
    .evictNeeded(evictNeeded),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/twoway_cache_chk.sv
module twoway_cache_chk #(
  parameter int BLOCK_BITS = 22,
  parameter int DATA_W     = 32,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cpuValid,
  input logic                  cpuWrite,
  input logic [BLOCK_BITS+1:0] cpuAddr,
  input logic [DATA_W-1:0]     cpuWdata,
  input logic                  cpuReady,
  input logic                  memReq,
  input logic                  memWrite,
  input logic [BLOCK_BITS-1:0] memAddr,
  input logic [DATA_W-1:0]     memWdata,
  input logic                  memAck
);

  // R2: completion only for a pending request
  p_ready_with_valid_r2: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> cpuValid);

  // R8: processor request held until completion (input assumption)
  p_cpu_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cpuValid && !cpuReady) |=> (cpuValid && $stable(cpuAddr) && $stable(cpuWrite) && $stable(cpuWdata)));

  // R8: no completion while memory traffic is outstanding
  p_no_ready_mid_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |-> !cpuReady);

  // R11: memory request steady until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memWrite) && $stable(memAddr) && $stable(memWdata)));

  // R6: write-back mode completes with no memory request
  p_wb_quiet_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (WRITE_BACK && cpuReady) |-> !memReq);

  // R7: a victim write-back is followed straight by the fill
  p_fill_after_evict_r7: assert property (@(posedge clk) disable iff (rst)
    (WRITE_BACK && memReq && memWrite && memAck) |=> (memReq && !memWrite));

  // R9: write-through memory write carries the processor's block and word
  p_wt_data_r9: assert property (@(posedge clk) disable iff (rst)
    (!WRITE_BACK && memReq && memWrite) |->
      (cpuValid && cpuWrite && memWdata == cpuWdata && memAddr == cpuAddr[BLOCK_BITS+1:2]));

endmodule

bind twoway_cache twoway_cache_chk #(
  .BLOCK_BITS(BLOCK_BITS),
  .DATA_W    (DATA_W),
  .WRITE_BACK(WRITE_BACK)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cpuValid(cpuValid),
  .cpuWrite(cpuWrite),
  .cpuAddr (cpuAddr),
  .cpuWdata(cpuWdata),
  .cpuReady(cpuReady),
  .memReq  (memReq),
  .memWrite(memWrite),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .memAck  (memAck)
);

// File: tb/twoway_cache_tb_top.sv
`timescale 1ns/1ps

module twoway_cache_memsim (
  input  logic        clk,
  input  logic        rst,
  input  logic        memReq,
  input  logic        memWrite,
  input  logic [21:0] memAddr,
  input  logic [31:0] memWdata,
  output logic        memAck,
  output logic [31:0] memRdata,
  output int          wrCount
);
  logic [31:0] store [logic [21:0]];

  function automatic logic [31:0] lookup(input logic [21:0] a);
    if (store.exists(a)) return store[a];
    return 32'hC0DE_0000 ^ {10'd0, a};
  endfunction

  initial begin
    memAck   = 1'b0;
    memRdata = '0;
    wrCount  = 0;
  end

  always @(posedge clk) begin
    if (memReq && memWrite && memAck) begin
      store[memAddr] = memWdata;
      wrCount = wrCount + 1;
    end
    if (memReq && !memAck) memRdata <= lookup(memAddr);
    memAck <= rst ? 1'b0 : (memReq && !memAck);
  end
endmodule

module twoway_cache_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // Write-back instance signals
  logic        wbValid = 1'b0, wbWrite = 1'b0;
  logic [23:0] wbAddr = '0;
  logic [31:0] wbWdata = '0, wbRdata, wbMemW, wbMemR;
  logic        wbReady, wbMemReq, wbMemWr, wbMemAck;
  logic [21:0] wbMemA;
  int          wbWrs;

  // Write-through instance signals
  logic        wtValid = 1'b0, wtWrite = 1'b0;
  logic [23:0] wtAddr = '0;
  logic [31:0] wtWdata = '0, wtRdata, wtMemW, wtMemR;
  logic        wtReady, wtMemReq, wtMemWr, wtMemAck;
  logic [21:0] wtMemA;
  int          wtWrs;

  twoway_cache #(.SET_BITS(6), .BLOCK_BITS(22), .DATA_W(32), .WRITE_BACK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cpuValid(wbValid), .cpuWrite(wbWrite), .cpuAddr(wbAddr),
    .cpuWdata(wbWdata), .cpuReady(wbReady), .cpuRdata(wbRdata), .memReq(wbMemReq),
    .memWrite(wbMemWr), .memAddr(wbMemA), .memWdata(wbMemW), .memAck(wbMemAck), .memRdata(wbMemR));

  twoway_cache_memsim wbMem_i (.clk(clk), .rst(rst), .memReq(wbMemReq), .memWrite(wbMemWr),
    .memAddr(wbMemA), .memWdata(wbMemW), .memAck(wbMemAck), .memRdata(wbMemR), .wrCount(wbWrs));

  twoway_cache #(.SET_BITS(6), .BLOCK_BITS(22), .DATA_W(32), .WRITE_BACK(1'b0)) dutWt_i (
    .clk(clk), .rst(rst), .cpuValid(wtValid), .cpuWrite(wtWrite), .cpuAddr(wtAddr),
    .cpuWdata(wtWdata), .cpuReady(wtReady), .cpuRdata(wtRdata), .memReq(wtMemReq),
    .memWrite(wtMemWr), .memAddr(wtMemA), .memWdata(wtMemW), .memAck(wtMemAck), .memRdata(wtMemR));

  twoway_cache_memsim wtMem_i (.clk(clk), .rst(rst), .memReq(wtMemReq), .memWrite(wtMemWr),
    .memAddr(wtMemA), .memWdata(wtMemW), .memAck(wtMemAck), .memRdata(wtMemR), .wrCount(wtWrs));

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  // kind: 0 = expect untouched memory word, 1 = expect expRd, 2 = no data check
  typedef struct packed {
    logic        wt;
    logic        wr;
    logic [15:0] tag;
    logic [5:0]  setI;
    logic [1:0]  off;
    logic [31:0] wdata;
    logic [1:0]  kind;
    logic [31:0] expRd;
    logic [3:0]  lat;
    logic [3:0]  wrs;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 27;
  localparam vec_t VECS [NVEC] = '{
    // write-back instance
    '{1'b0, 1'b0, 16'h0001, 6'd5,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd0, 4'd4},  // R4 way0 fill
    '{1'b0, 1'b0, 16'h0001, 6'd5,  2'd0, 32'h0,        2'd0, 32'h0,        4'd0, 4'd0, 4'd2},  // R2 read hit
    '{1'b0, 1'b0, 16'h0002, 6'd5,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd0, 4'd4},  // R4 way1 fill
    '{1'b0, 1'b1, 16'h0001, 6'd5,  2'd0, 32'h11111111, 2'd2, 32'h0,        4'd0, 4'd0, 4'd6},  // R6 write hit
    '{1'b0, 1'b0, 16'h0001, 6'd5,  2'd0, 32'h0,        2'd1, 32'h11111111, 4'd0, 4'd0, 4'd6},  // R6 cached word
    '{1'b0, 1'b0, 16'h0003, 6'd5,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd0, 4'd7},  // R7 clean victim
    '{1'b0, 1'b0, 16'h0004, 6'd5,  2'd0, 32'h0,        2'd0, 32'h0,        4'd5, 4'd1, 4'd7},  // R7 dirty victim
    '{1'b0, 1'b0, 16'h0001, 6'd5,  2'd0, 32'h0,        2'd1, 32'h11111111, 4'd3, 4'd1, 4'd7},  // R7 written data
    '{1'b0, 1'b0, 16'h0001, 6'd5,  2'd3, 32'h0,        2'd1, 32'h11111111, 4'd0, 4'd1, 4'd3},  // R3 offset ignored
    '{1'b0, 1'b0, 16'h0003, 6'd0,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd1, 4'd3},  // R3 set 0
    '{1'b0, 1'b0, 16'hFFFF, 6'd63, 2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd1, 4'd3},  // R3 top set
    '{1'b0, 1'b1, 16'h0001, 6'd5,  2'd0, 32'h22222222, 2'd2, 32'h0,        4'd0, 4'd1, 4'd6},  // R6
    '{1'b0, 1'b1, 16'h0004, 6'd5,  2'd0, 32'h33333333, 2'd2, 32'h0,        4'd0, 4'd1, 4'd6},  // R6
    '{1'b0, 1'b0, 16'h0007, 6'd5,  2'd0, 32'h0,        2'd0, 32'h0,        4'd5, 4'd2, 4'd5},  // R5 use-bit victim
    '{1'b0, 1'b0, 16'h0001, 6'd5,  2'd0, 32'h0,        2'd1, 32'h22222222, 4'd5, 4'd3, 4'd5},  // R5 R8
    '{1'b0, 1'b0, 16'h0004, 6'd5,  2'd0, 32'h0,        2'd1, 32'h33333333, 4'd3, 4'd3, 4'd8},  // R8 clean path
    '{1'b0, 1'b1, 16'h0009, 6'd20, 2'd0, 32'h44444444, 2'd2, 32'h0,        4'd3, 4'd3, 4'd10}, // R10 write miss
    '{1'b0, 1'b0, 16'h0009, 6'd20, 2'd0, 32'h0,        2'd1, 32'h44444444, 4'd0, 4'd3, 4'd10}, // R10
    '{1'b0, 1'b0, 16'h0003, 6'd0,  2'd0, 32'h0,        2'd0, 32'h0,        4'd0, 4'd3, 4'd3},  // R3 other set kept
    // write-through instance
    '{1'b1, 1'b0, 16'h0001, 6'd3,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd0, 4'd4},  // R4
    '{1'b1, 1'b1, 16'h0001, 6'd3,  2'd0, 32'hAAAA0001, 2'd2, 32'h0,        4'd2, 4'd1, 4'd9},  // R9 write hit
    '{1'b1, 1'b0, 16'h0001, 6'd3,  2'd0, 32'h0,        2'd1, 32'hAAAA0001, 4'd0, 4'd1, 4'd9},  // R9 cached
    '{1'b1, 1'b0, 16'h0002, 6'd3,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd1, 4'd4},  // R4
    '{1'b1, 1'b0, 16'h0005, 6'd3,  2'd0, 32'h0,        2'd0, 32'h0,        4'd3, 4'd1, 4'd9},  // R9 no write-back
    '{1'b1, 1'b0, 16'h0001, 6'd3,  2'd0, 32'h0,        2'd1, 32'hAAAA0001, 4'd3, 4'd1, 4'd9},  // R9 memory valid
    '{1'b1, 1'b1, 16'h0006, 6'd3,  2'd0, 32'hBBBB0002, 2'd2, 32'h0,        4'd5, 4'd2, 4'd10}, // R10 write miss
    '{1'b1, 1'b0, 16'h0006, 6'd3,  2'd0, 32'h0,        2'd1, 32'hBBBB0002, 4'd0, 4'd2, 4'd10}  // R10
  };

  function automatic logic [31:0] initWord(input logic [21:0] blk);
    return 32'hC0DE_0000 ^ {10'd0, blk};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input bit wt, input logic wr, input logic [23:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(posedge clk); #1;
    if (wt) begin
      wtValid = 1'b1; wtWrite = wr; wtAddr = a; wtWdata = d;
    end else begin
      wbValid = 1'b1; wbWrite = wr; wbAddr = a; wbWdata = d;
    end
    lat = 0;
    @(negedge clk);
    while (!(wt ? wtReady : wbReady) && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = wt ? wtRdata : wbRdata;
    @(posedge clk); #1;
    wtValid = 1'b0;
    wbValid = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: idle outputs after reset
    @(negedge clk);
    check(!wbReady && !wbMemReq, "R1 reset idle wb", {30'd0, wbReady, wbMemReq}, 32'd0);
    check(!wtReady && !wtMemReq, "R1 reset idle wt", {30'd0, wtReady, wtMemReq}, 32'd0);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] expD;
      int wrsNow;
      access(VECS[i].wt, VECS[i].wr, {VECS[i].tag, VECS[i].setI, VECS[i].off}, VECS[i].wdata, rd, lat);
      wrsNow = VECS[i].wt ? wtWrs : wbWrs;
      check(lat == int'(VECS[i].lat), $sformatf("R%0d vec %0d latency", VECS[i].req, i),
            32'(lat), 32'(VECS[i].lat));
      check(wrsNow == int'(VECS[i].wrs), $sformatf("R%0d vec %0d memory writes", VECS[i].req, i),
            32'(wrsNow), 32'(VECS[i].wrs));
      if (VECS[i].kind != 2'd2) begin
        expD = (VECS[i].kind == 2'd0) ? initWord({VECS[i].tag, VECS[i].setI}) : VECS[i].expRd;
        check(rd == expD, $sformatf("R%0d vec %0d read data", VECS[i].req, i), rd, expD);
      end
    end

    // R1: reset invalidates lines that were cached
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!wbReady && !wbMemReq, "R1 idle after mid-run reset", {30'd0, wbReady, wbMemReq}, 32'd0);
    access(1'b0, 1'b0, {16'h0004, 6'd5, 2'd0}, 32'h0, rd, lat);
    check(lat == 3, "R1 cached block misses after reset", 32'(lat), 32'd3);
    check(rd == 32'h33333333, "R1 refetched data", rd, 32'h33333333);
    check(wbWrs == 3, "R1 reset causes no memory write", 32'(wbWrs), 32'd3);

    // R2: no completion without a request
    @(negedge clk);
    check(!wbReady && !wtReady, "R2 ready low while idle", {30'd0, wbReady, wtReady}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule